// File: doc/BRIEF.md
# Dual Threshold and Rate Alarm

This block watches two sensor readings, one per alarm channel, chosen from a set of 14-bit two's-complement sensor words. On every sample strobe, each channel checks its selected word. In level mode it compares the word itself against a signed threshold. In rate mode it compares the change of the word over a window of K sample strobes against the threshold. The threshold word carries a direction bit that chooses between "alarm when greater" and "alarm when less".

When a condition is met, the channel's flag is latched into a status word. The status word clears when it is read. If the condition still holds on a later sample, the flag sets again. A single alarm pin combines the flags that are enabled for it, and a polarity bit chooses whether the pin is active high or active low.

Each rate channel keeps its own sample history. The history is restarted whenever the mode, the source or the window length of that channel changes.

Top module: `dual_alarm_monitor`

## Requirements
- R1: After reset, both status flags are 0 and the alarm pin equals the polarity-select input.
- R2: In level mode (mode bit 0), a sample strobe sets the channel flag when the selected word is strictly greater than the threshold (direction bit 1) or strictly less than it (direction bit 0). Both values are compared as signed numbers, and equality never alarms.
- R3: The 16-bit threshold word is decoded as follows: bit 15 is the direction, bits 13:0 are the signed threshold, and bit 14 has no effect.
- R4: In rate mode (mode bit 1), the quantity compared is the current word minus the word captured K strobes earlier. K is the channel's 8-bit window value, and K = 0 behaves exactly like K = 1.
- R5: In rate mode, no alarm can occur until K samples have been stored since the channel's history was last cleared.
- R6: The rate difference is formed at 15 bits. For example, a step from -8192 to +8191 gives +16383, which does not wrap.
- R7: A flag stays set until a status read. A read with no sample strobe leaves the flag at 0 in the next cycle. Without a sample strobe, no flag can set.
- R8: When a status read and an alarming sample fall in the same cycle, the flag is set afterwards.
- R9: A change of a channel's mode, source or window value in any cycle clears that channel's flag and its history. A sample strobe in that same cycle is discarded for that channel. A change of the threshold alone clears nothing.
- R10: The alarm pin is the OR of the flags whose enable bit is set, inverted when the polarity-select input is 1.
- R11: The two channels are independent. The source select value i picks the sensor word at bits i*14+13 down to i*14 of the packed source bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_vld | input | 1 | New sensor words are present this cycle |
| src_words | input | 56 | Four packed 14-bit sensor words, word i at bits i*14 upward |
| ch_src_sel | input | 4 | Per-channel 2-bit source select |
| ch_rate_mode | input | 2 | Per-channel mode, 0 = level, 1 = rate of change |
| ch_thresh | input | 32 | Per-channel 16-bit threshold word |
| ch_window | input | 16 | Per-channel 8-bit window K |
| alarm_en | input | 2 | Per-channel enable onto the alarm pin |
| pin_invert | input | 1 | 1 inverts the alarm pin (active low) |
| status_rd | input | 1 | Status read strobe, clears the flags |
| status_flags | output | 2 | Latched alarm flags |
| alarm_pin | output | 1 | Combined alarm output |

## Verification
A status read and an alarming sample can fall in the same cycle. Two outcomes are possible: the clear could swallow the new alarm, or the new alarm is kept. The bench drives both strobes together on purpose in a directed step, and also at random throughout the random phase. It expects the flag to be set in the following cycle.

A configuration change coinciding with a sample strobe is a second case of this kind. The bench provokes it and expects a cleared flag, with no trace of the discarded sample in later rate comparisons.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    typedef enum logic {
        CMP_LEVEL = 1'b0,
        CMP_RATE  = 1'b1
    } cmp_mode_e;

    // Signed comparison in the chosen direction; equality never alarms.
    function automatic logic alarm_hit(input logic above, input int lhs, input int rhs);
        return above ? (lhs > rhs) : (lhs < rhs);
    endfunction

endpackage

// File: rtl/alarm_history.sv
module alarm_history #(
    parameter int DW = 14,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/alarm_channel.sv
module alarm_channel
    import alarm_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int SEL_W  = 2,
    parameter int WIN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_vld,
    input  logic [DATA_W-1:0] sample,
    input  logic              cfg_rate,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [WIN_W-1:0]  cfg_win,
    input  logic              thr_gt,
    input  logic [DATA_W-1:0] thr_val,
    input  logic              status_rd,
    output logic              flag
);
    typedef struct packed {
        logic             rate;
        logic [SEL_W-1:0] sel;
        logic [WIN_W-1:0] win;
        logic [WIN_W-1:0] fill;
        logic [WIN_W-1:0] wptr;
        logic             flag;
    } chan_st_t;

    chan_st_t st_d, st_q;

    logic [WIN_W-1:0]         win_eff;
    logic [WIN_W-1:0]         rd_addr;
    logic [DATA_W-1:0]        old_val;
    logic                     push;
    logic                     hit;
    logic                     cfg_chg;
    logic signed [DATA_W:0]   delta;

    // A window of zero means one sample.
    assign win_eff = (cfg_win == '0) ? WIN_W'(1) : cfg_win;
    assign rd_addr = st_q.wptr - win_eff;

    alarm_history #(
        .DW (DATA_W),
        .AW (WIN_W)
    ) u_hist (
        .clk   (clk),
        .we    (push),
        .waddr (st_q.wptr),
        .wdata (sample),
        .raddr (rd_addr),
        .rdata (old_val)
    );

    always_comb begin
        st_d    = st_q;
        push    = 1'b0;
        hit     = 1'b0;
        delta   = $signed({sample[DATA_W-1], sample})
                - $signed({old_val[DATA_W-1], old_val});
        cfg_chg = (cfg_rate != st_q.rate) || (cfg_sel != st_q.sel) || (cfg_win != st_q.win);

        st_d.rate = cfg_rate;
        st_d.sel  = cfg_sel;
        st_d.win  = cfg_win;

        if (cfg_chg) begin
            st_d.fill = '0;
            st_d.flag = 1'b0;
        end else begin
            if (sample_vld) begin
                push = 1'b1;
                if (cmp_mode_e'(cfg_rate) == CMP_RATE) begin
                    if (st_q.fill >= win_eff) begin
                        hit = alarm_hit(thr_gt, int'(delta), int'($signed(thr_val)));
                    end
                end else begin
                    hit = alarm_hit(thr_gt, int'($signed(sample)), int'($signed(thr_val)));
                end
                st_d.wptr = st_q.wptr + WIN_W'(1);
                if (st_q.fill != '1) begin
                    st_d.fill = st_q.fill + WIN_W'(1);
                end
            end
            st_d.flag = (st_q.flag & ~status_rd) | hit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/dual_alarm_monitor.sv
module dual_alarm_monitor #(
    parameter int DATA_W = 14,
    parameter int NSRC   = 4,
    parameter int WIN_W  = 8,
    parameter int NCH    = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_vld,
    input  logic [NSRC*DATA_W-1:0]  src_words,
    input  logic [NCH*$clog2(NSRC)-1:0] ch_src_sel,
    input  logic [NCH-1:0]          ch_rate_mode,
    input  logic [NCH*(DATA_W+2)-1:0] ch_thresh,
    input  logic [NCH*WIN_W-1:0]    ch_window,
    input  logic [NCH-1:0]          alarm_en,
    input  logic                    pin_invert,
    input  logic                    status_rd,
    output logic [NCH-1:0]          status_flags,
    output logic                    alarm_pin
);
    localparam int SEL_W = $clog2(NSRC);
    localparam int THR_W = DATA_W + 2;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [SEL_W-1:0]  sel;
        logic [DATA_W-1:0] value;
        logic [THR_W-1:0]  thr_word;
        logic              thr_pad_unused;

        assign sel            = ch_src_sel[g*SEL_W +: SEL_W];
        assign value          = src_words[sel*DATA_W +: DATA_W];
        assign thr_word       = ch_thresh[g*THR_W +: THR_W];
        assign thr_pad_unused = thr_word[DATA_W];

        alarm_channel #(
            .DATA_W (DATA_W),
            .SEL_W  (SEL_W),
            .WIN_W  (WIN_W)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .sample_vld (sample_vld),
            .sample     (value),
            .cfg_rate   (ch_rate_mode[g]),
            .cfg_sel    (sel),
            .cfg_win    (ch_window[g*WIN_W +: WIN_W]),
            .thr_gt     (thr_word[THR_W-1]),
            .thr_val    (thr_word[DATA_W-1:0]),
            .status_rd  (status_rd),
            .flag       (status_flags[g])
        );
    end

    assign alarm_pin = (|(status_flags & alarm_en)) ^ pin_invert;

endmodule

// File: rtl/alarm_monitor_checks.sv
module alarm_monitor_checks #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sample_vld,
    input logic           status_rd,
    input logic [NCH-1:0] ch_rate_mode,
    input logic [NCH-1:0] alarm_en,
    input logic           pin_invert,
    input logic [NCH-1:0] status_flags,
    input logic           alarm_pin
);
    // R7: a read without a sample leaves every flag cleared
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !sample_vld) |=> (status_flags == '0));

    // R7: without a sample strobe no new flag appears
    a_r7_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_vld) |=> ((status_flags & ~$past(status_flags)) == '0));

    // R9: a mode change on channel 0 clears its flag
    a_r9_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_rate_mode[0] != $past(ch_rate_mode[0])) |=> !status_flags[0]);

    // R10: no enabled flag means the pin rests at its idle level
    a_r10_pin_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_invert && ((status_flags & alarm_en) == '0)) |-> alarm_pin);

    a_r10_pin_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_invert && ((status_flags & alarm_en) == '0)) |-> !alarm_pin);

endmodule

bind dual_alarm_monitor alarm_monitor_checks #(.NCH(NCH)) u_alarm_checks (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_vld   (sample_vld),
    .status_rd    (status_rd),
    .ch_rate_mode (ch_rate_mode),
    .alarm_en     (alarm_en),
    .pin_invert   (pin_invert),
    .status_flags (status_flags),
    .alarm_pin    (alarm_pin)
);

// File: tb/test_dual_alarm_monitor.sv
module test_dual_alarm_monitor;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_vld = 1'b0;
    logic [55:0] src_words = '0;
    logic [3:0]  ch_src_sel = '0;
    logic [1:0]  ch_rate_mode = '0;
    logic [31:0] ch_thresh = '0;
    logic [15:0] ch_window = '0;
    logic [1:0]  alarm_en = '0;
    logic        pin_invert = 1'b1;
    logic        status_rd = 1'b0;
    logic [1:0]  status_flags;
    logic        alarm_pin;

    int    errors = 0;
    int    checks = 0;
    string cur = "R1";

    int   hist [2][256];
    int   fill [2];
    int   wp   [2];
    bit   ef   [2];
    logic       pm [2];
    logic [1:0] ps [2];
    logic [7:0] pw [2];

    always #2.5 clk = ~clk;

    dual_alarm_monitor i_dual_alarm_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .sample_vld   (sample_vld),
        .src_words    (src_words),
        .ch_src_sel   (ch_src_sel),
        .ch_rate_mode (ch_rate_mode),
        .ch_thresh    (ch_thresh),
        .ch_window    (ch_window),
        .alarm_en     (alarm_en),
        .pin_invert   (pin_invert),
        .status_rd    (status_rd),
        .status_flags (status_flags),
        .alarm_pin    (alarm_pin)
    );

    function automatic int sx14(input logic [13:0] x);
        return int'($signed(x));
    endfunction

    function automatic bit cmp(input bit above, input int a, input int b);
        return above ? (a > b) : (a < b);
    endfunction

    // Expected state after the coming clock edge, from the requirements.
    task automatic model_update();
        for (int c = 0; c < 2; c++) begin
            logic       m;
            logic [1:0] s;
            logic [7:0] w;
            logic [15:0] tw;
            bit hit;
            m  = ch_rate_mode[c];
            s  = ch_src_sel[c*2 +: 2];
            w  = ch_window[c*8 +: 8];
            tw = ch_thresh[c*16 +: 16];
            if (m != pm[c] || s != ps[c] || w != pw[c]) begin
                fill[c] = 0;
                ef[c]   = 1'b0;
            end else begin
                hit = 1'b0;
                if (sample_vld) begin
                    int v, t, k;
                    v = sx14(src_words[s*14 +: 14]);
                    t = sx14(tw[13:0]);
                    if (!m) begin
                        hit = cmp(tw[15], v, t);
                    end else begin
                        k = (w == 0) ? 1 : int'(w);
                        if (fill[c] >= k) hit = cmp(tw[15], v - hist[c][(wp[c] - k) & 255], t);
                    end
                    hist[c][wp[c]] = v;
                    wp[c] = (wp[c] + 1) & 255;
                    if (fill[c] < 255) fill[c]++;
                end
                ef[c] = (status_rd ? 1'b0 : ef[c]) | hit;
            end
            pm[c] = m; ps[c] = s; pw[c] = w;
        end
    endtask

    task automatic check_outputs();
        logic [1:0] ex;
        logic       ep;
        ex = {ef[1], ef[0]};
        ep = (|(ex & alarm_en)) ^ pin_invert;
        checks++;
        if (status_flags !== ex) begin
            errors++;
            $display("FAIL %s flags got %b exp %b", cur, status_flags, ex);
        end
        checks++;
        if (alarm_pin !== ep) begin
            errors++;
            $display("FAIL %s pin got %b exp %b", cur, alarm_pin, ep);
        end
    endtask

    task automatic step(input bit vld, input bit rd);
        sample_vld = vld;
        status_rd  = rd;
        model_update();
        @(posedge clk);
        #1;
        check_outputs();
        sample_vld = 1'b0;
        status_rd  = 1'b0;
    endtask

    task automatic put_word(input int idx, input int val);
        src_words[idx*14 +: 14] = 14'(val);
    endtask

    task automatic set_ch(input int c, input bit rate, input int sel, input int win,
                          input bit gt, input int thr);
        ch_rate_mode[c]        = rate;
        ch_src_sel[c*2 +: 2]   = 2'(sel);
        ch_window[c*8 +: 8]    = 8'(win);
        ch_thresh[c*16 +: 16]  = {gt, 1'b0, 14'(thr)};
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int c = 0; c < 2; c++) begin
            fill[c] = 0; wp[c] = 0; ef[c] = 1'b0;
            pm[c] = 1'b0; ps[c] = 2'd0; pw[c] = 8'd0;
        end
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: reset state, pin follows polarity select
        cur = "R1";
        step(0, 0);

        // R11 / R2: ch0 level on word 1 greater than 100, ch1 level on word 2 less than -50
        alarm_en = 2'b11;
        pin_invert = 1'b0;
        set_ch(0, 0, 1, 0, 1, 100);
        set_ch(1, 0, 2, 0, 0, -50);
        cur = "R11";
        step(0, 0);
        put_word(1, 100); put_word(2, -50);
        cur = "R2";
        step(1, 0);                  // equality: no alarm on either
        put_word(1, 101); put_word(2, 0);
        step(1, 0);                  // ch0 only
        put_word(0, 5000); put_word(3, -5000); put_word(1, 0); put_word(2, -51);
        cur = "R11";
        step(1, 1);                  // ch1 only, other words ignored
        step(0, 1);

        // R3: bit 14 of the threshold has no effect
        cur = "R3";
        ch_thresh[14] = 1'b1;
        put_word(1, 101);
        step(1, 0);
        put_word(1, 100);
        step(0, 1);
        step(1, 0);
        ch_thresh[14] = 1'b0;

        // R4: rate mode with K=0 acts like K=1
        cur = "R4";
        set_ch(0, 1, 1, 0, 1, 150);
        step(0, 0);
        put_word(1, 0);   step(1, 0);
        put_word(1, 200); step(1, 0);    // +200 > 150
        put_word(1, 300); step(1, 1);    // +100, read clears, no hit
        step(0, 0);

        // R5: K=5, no comparison before five stored samples
        cur = "R5";
        set_ch(0, 1, 1, 5, 1, 10);
        step(0, 0);
        for (int i = 0; i < 8; i++) begin
            put_word(1, i * 100);
            step(1, 0);
        end

        // R6: full-scale step in rate mode must not wrap
        cur = "R6";
        set_ch(0, 1, 1, 1, 1, 8191);
        step(0, 0);
        put_word(1, -8192); step(1, 0);
        put_word(1, 8191);  step(1, 0);
        cur = "R7";
        step(0, 0);
        step(0, 1);
        step(0, 0);

        // R8: read and alarming sample together
        cur = "R8";
        set_ch(0, 0, 1, 0, 1, 0);
        step(0, 0);
        put_word(1, 7);
        step(1, 0);
        step(1, 1);
        step(0, 0);

        // R9: config change clears flag and discards coincident sample
        cur = "R9";
        ch_thresh[13:0] = 14'd3;     // threshold only: no clear
        step(0, 0);
        ch_src_sel[1:0] = 2'd3;
        put_word(3, 9000 - 16384);
        step(1, 0);
        set_ch(0, 1, 3, 1, 1, 10);
        step(0, 0);
        put_word(3, 0);  step(1, 0);
        put_word(3, 20); step(1, 0);
        ch_rate_mode[0] = 1'b0;
        step(1, 0);

        // R10: enable and polarity combinations
        cur = "R10";
        set_ch(1, 0, 2, 0, 1, -8192);
        put_word(2, 0);
        step(1, 0);
        for (int i = 0; i < 8; i++) begin
            alarm_en   = 2'(i);
            pin_invert = i[2];
            step(0, 0);
        end

        // Random mix
        cur = "RND";
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 150) == 0) begin
                int c;
                c = $urandom % 2;
                set_ch(c, $urandom % 2, $urandom % 4, $urandom % 6,
                       $urandom % 2, int'($urandom % 4000) - 2000);
            end
            if (($urandom % 40) == 0) begin
                alarm_en   = 2'($urandom);
                pin_invert = 1'($urandom);
            end
            src_words = {$urandom, $urandom};
            step(($urandom % 3) != 0, ($urandom % 4) == 0);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule